// File: doc/BRIEF.md
# Bit-Serial Reflected CRC-32 Engine

This block accumulates a 32-bit cyclic redundancy check over a byte stream, one register shift per clock. The register shifts toward bit 0 and uses the bit-reversed form 0xEDB88320 of the generator 0x04C11DB7. Each accepted byte is folded into the low end of the register and then shifted through eight steps, least-significant bit first. Every message bit therefore takes part in the decision to fold in the polynomial. No zero padding is appended and no inversion is applied at the end. The register contents after the last byte are the check value. This is the variant whose check value for the nine ASCII digits "123456789" is 0x340BC6D9.

Bytes arrive on a valid/ready stream. The producer holds `in_valid` and `in_data` steady until it sees `in_ready` high at a rising edge, and a transfer takes place exactly at that edge. `in_ready` drops for seven cycles while the byte is shifted, so the stream accepts at most one byte every eight cycles. Anything presented while `in_ready` is low is not taken. `start` is a plain control pulse that opens a new message by reloading the all-ones seed. `crc_out` always shows the live register. It holds the finished value for a message whenever `in_ready` is high after that message's last byte.

Top module: `crc32r_serial`

## Requirements
- R1: On each shift step the register moves right by one bit. When the bit leaving position 0 is 1, the shifted value is XORed with 0xEDB88320.
- R2: A `start` pulse with no byte accepted in that cycle sets `crc_out` to 0xFFFFFFFF and leaves `in_ready` high on the following cycle.
- R3: An accepted byte is XORed into register bits 7:0 before its first shift, so its bit 0 is consumed first.
- R4: No final inversion is applied. After "123456789" (0x31..0x39) from a fresh start, `crc_out` reads 0x340BC6D9.
- R5: A byte is accepted at a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is then low for exactly seven cycles and high again in the eighth.
- R6: Bytes presented while `in_ready` is low are not taken and do not change the result. While idle with no `in_valid` and no `start`, `crc_out` holds.
- R7: When `start` and an accepted byte coincide, the seed is reloaded first and that byte is processed from 0xFFFFFFFF.
- R8: A `start` pulse while a byte is being shifted abandons that byte. `crc_out` becomes 0xFFFFFFFF and `in_ready` goes high on the next cycle.
- R9: A message of zero bytes leaves `crc_out` at 0xFFFFFFFF.
- R10: For any message, the final `crc_out` equals the bytewise reflected algorithm seeded with 0xFFFFFFFF.
- R11: Synchronous reset `rst` sets `crc_out` to 0xFFFFFFFF and `in_ready` high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse: reload the seed for a new message |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte stream data |
| in_ready | output | 1 | High when a byte can be accepted |
| crc_out | output | 32 | Live CRC register |

## Verification
The bound checker watches the per-cycle rules on every clock. These are the single-bit shift with conditional polynomial fold while busy, the seven-cycle ready gap and its end, seed reload on reset and on `start`, and the register holding while idle. Only the bench scenarios can show end-to-end correctness. The scenarios cover the known check value, the coincident start-plus-byte case, abandoning a byte mid-shift, bytes offered under back-pressure being ignored, empty messages, and agreement with a reference loop over random messages with random gaps.

// File: rtl/crc32r_pkg.sv
package crc32r_pkg;

  localparam int unsigned CRC_W_DEF  = 32;
  localparam int unsigned BYTE_W_DEF = 8;
  localparam logic [31:0] POLY_DEF   = 32'hEDB8_8320;
  localparam logic [31:0] SEED_DEF   = 32'hFFFF_FFFF;

  // Per-cycle command from the sequencer to the datapath
  typedef enum logic [2:0] {
    CMD_HOLD         = 3'd0,
    CMD_RELOAD       = 3'd1,
    CMD_ACCEPT       = 3'd2,
    CMD_ACCEPT_FRESH = 3'd3,
    CMD_SHIFT        = 3'd4
  } crc_cmd_e;

endpackage

// File: rtl/crc32r_step.sv
// One reflected LFSR step: shift right, fold polynomial when bit 0 is set.
module crc32r_step #(
  parameter int unsigned W    = 32,
  parameter logic [W-1:0] POLY = 32'hEDB8_8320
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign nxt[i] = cur[0] & POLY[i];
    end else begin : g_mid
      assign nxt[i] = cur[i+1] ^ (cur[0] & POLY[i]);
    end
  end
endmodule

// File: rtl/crc32r_seq.sv
// Shift counter and stream acceptance.
module crc32r_seq
  import crc32r_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  logic     in_valid,
  output logic     in_ready,
  output crc_cmd_e cmd
);
  localparam int unsigned CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0] left_q;
  logic             take;

  assign in_ready = (left_q == '0);
  assign take     = in_valid && in_ready;

  always_comb begin
    if (take)                cmd = start ? CMD_ACCEPT_FRESH : CMD_ACCEPT;
    else if (start)          cmd = CMD_RELOAD;
    else if (!in_ready)      cmd = CMD_SHIFT;
    else                     cmd = CMD_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else begin
      unique case (cmd)
        CMD_ACCEPT, CMD_ACCEPT_FRESH: left_q <= LAST;
        CMD_RELOAD:                   left_q <= '0;
        CMD_SHIFT:                    left_q <= left_q - 1'b1;
        default:                      left_q <= left_q;
      endcase
    end
  end
endmodule

// File: rtl/crc32r_datapath.sv
// CRC register with byte fold-in and a single shared step unit.
module crc32r_datapath
  import crc32r_pkg::*;
#(
  parameter int unsigned  W      = 32,
  parameter int unsigned  BYTE_W = 8,
  parameter logic [W-1:0] POLY   = 32'hEDB8_8320,
  parameter logic [W-1:0] SEED   = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  crc_cmd_e          cmd,
  input  logic [BYTE_W-1:0] in_data,
  output logic [W-1:0]      crc
);
  localparam int unsigned PAD = W - BYTE_W;

  logic [W-1:0] crc_q, base, mixed, step_in, step_out;

  assign base    = (cmd == CMD_ACCEPT_FRESH) ? SEED : crc_q;
  assign mixed   = base ^ {{PAD{1'b0}}, in_data};
  assign step_in = (cmd == CMD_ACCEPT || cmd == CMD_ACCEPT_FRESH) ? mixed : crc_q;

  crc32r_step #(.W(W), .POLY(POLY)) u_step (
    .cur (step_in),
    .nxt (step_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= SEED;
    end else begin
      unique case (cmd)
        CMD_RELOAD:                              crc_q <= SEED;
        CMD_ACCEPT, CMD_ACCEPT_FRESH, CMD_SHIFT: crc_q <= step_out;
        default:                                 crc_q <= crc_q;
      endcase
    end
  end

  assign crc = crc_q;
endmodule

// File: rtl/crc32r_serial.sv
module crc32r_serial
  import crc32r_pkg::*;
#(
  parameter int unsigned  W      = CRC_W_DEF,
  parameter int unsigned  BYTE_W = BYTE_W_DEF,
  parameter logic [W-1:0] POLY   = POLY_DEF,
  parameter logic [W-1:0] SEED   = SEED_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic [W-1:0]      crc_out
);
  crc_cmd_e cmd;

  crc32r_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .cmd      (cmd)
  );

  crc32r_datapath #(.W(W), .BYTE_W(BYTE_W), .POLY(POLY), .SEED(SEED)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .in_data (in_data),
    .crc     (crc_out)
  );
endmodule

// File: rtl/crc32r_serial_chk.sv
module crc32r_serial_chk #(
  parameter int unsigned  W      = 32,
  parameter int unsigned  BYTE_W = 8,
  parameter logic [W-1:0] POLY   = 32'hEDB8_8320,
  parameter logic [W-1:0] SEED   = 32'hFFFF_FFFF
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              in_valid,
  input logic [BYTE_W-1:0] in_data,
  input logic              in_ready,
  input logic [W-1:0]      crc_out
);
  localparam int unsigned RUN_W = $clog2(BYTE_W) + 2;

  // consecutive cycles with in_ready low, counted before this cycle
  logic [RUN_W-1:0] low_run;
  always_ff @(posedge clk) begin
    if (rst || in_ready) low_run <= '0;
    else                 low_run <= low_run + 1'b1;
  end

  p_reset_seed_r11: assert property (@(posedge clk)
    rst |=> (crc_out == SEED && in_ready));

  p_start_reload_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !(in_valid && in_ready)) |=> (crc_out == SEED && in_ready));

  p_accept_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  p_busy_bound_r5: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (low_run < RUN_W'(BYTE_W - 1)));

  p_ready_returns_r5: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && low_run == RUN_W'(BYTE_W - 2)) |=> in_ready);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid && !start) |=> ($stable(crc_out) && in_ready));

  p_shift_step_r1: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !start) |=>
      (crc_out == (({1'b0, $past(crc_out[W-1:1])}) ^ ($past(crc_out[0]) ? POLY : '0))));

  wire unused_ok = ^in_data;
endmodule

bind crc32r_serial crc32r_serial_chk #(
  .W(W), .BYTE_W(BYTE_W), .POLY(POLY), .SEED(SEED)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .in_valid (in_valid),
  .in_data  (in_data),
  .in_ready (in_ready),
  .crc_out  (crc_out)
);

// File: tb/crc32r_serial_test.sv
module crc32r_serial_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic [31:0] crc_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          chk_req = 1'b0;

  always #2 clk = ~clk;

  crc32r_serial uut (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .crc_out(crc_out)
  );

  function automatic logic [31:0] ref_byte(logic [31:0] r, logic [7:0] b);
    r = r ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // driver side of the scoreboard: push expectation, wait for the monitor
  task automatic expect_result(string tag, logic [31:0] exp);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    chk_req = 1'b1;
    wait (!chk_req);
  endtask

  // monitor: compares the finished register once the engine is idle
  initial begin
    forever begin
      @(negedge clk);
      if (chk_req && in_ready && exp_q.size() > 0) begin
        check(tag_q.pop_front(), crc_out, exp_q.pop_front());
        chk_req = 1'b0;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  digits [9];
    for (int i = 0; i < 9; i++) digits[i] = 8'h31 + 8'(i);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset crc", crc_out, 32'hFFFFFFFF);
    check("R11 reset ready", {31'h0, in_ready}, 32'h1);

    // R9: empty message
    pulse_start();
    expect_result("R9 empty message", 32'hFFFFFFFF);

    // R4 / R1 / R3: check string
    pulse_start();
    for (int i = 0; i < 9; i++) send_byte(digits[i]);
    expect_result("R4 check string", 32'h340BC6D9);

    // R3: single byte 0x01 -> exercises LSB-first fold
    pulse_start();
    send_byte(8'h01);
    expect_result("R3 single byte 01", ref_byte(32'hFFFFFFFF, 8'h01));
    pulse_start();
    send_byte(8'h80);
    expect_result("R3 single byte 80", ref_byte(32'hFFFFFFFF, 8'h80));

    // R5: ready gap after an accept
    pulse_start();
    send_byte(8'hA5);
    for (int i = 0; i < 7; i++) begin
      check("R5 ready low during shift", {31'h0, in_ready}, 32'h0);
      @(negedge clk);
    end
    check("R5 ready back on eighth cycle", {31'h0, in_ready}, 32'h1);
    check("R1 one byte result", crc_out, ref_byte(32'hFFFFFFFF, 8'hA5));

    // R6: bytes offered under back-pressure are ignored
    pulse_start();
    send_byte(8'h3C);
    in_valid = 1'b1;
    in_data  = 8'hEE;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    expect_result("R6 busy byte ignored", ref_byte(32'hFFFFFFFF, 8'h3C));
    r = crc_out;
    repeat (5) @(negedge clk);
    check("R6 idle hold", crc_out, r);

    // R7: start coincident with first byte after a dirty register
    send_byte(8'h55);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    start    = 1'b1;
    in_valid = 1'b1;
    in_data  = digits[0];
    @(negedge clk);
    start    = 1'b0;
    in_valid = 1'b0;
    for (int i = 1; i < 9; i++) send_byte(digits[i]);
    expect_result("R7 start with byte", 32'h340BC6D9);

    // R8: start mid-shift abandons the byte
    send_byte(8'hC3);
    @(negedge clk);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 abort reload", crc_out, 32'hFFFFFFFF);
    check("R8 abort ready", {31'h0, in_ready}, 32'h1);
    for (int i = 0; i < 9; i++) send_byte(digits[i]);
    expect_result("R8 message after abort", 32'h340BC6D9);

    // R2: plain reload with no byte
    pulse_start();
    check("R2 start reload", crc_out, 32'hFFFFFFFF);

    // R10: random messages, random gaps
    for (int m = 0; m < 24; m++) begin
      int len;
      len = $urandom_range(0, 12);
      pulse_start();
      r = 32'hFFFFFFFF;
      for (int i = 0; i < len; i++) begin
        logic [7:0] b;
        b = 8'($urandom);
        r = ref_byte(r, b);
        send_byte(b);
        repeat ($urandom_range(0, 3)) @(negedge clk);
      end
      expect_result("R10 random message", r);
    end

    // R11: reset in the middle of a byte
    send_byte(8'h77);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 mid-byte reset crc", crc_out, 32'hFFFFFFFF);
    check("R11 mid-byte reset ready", {31'h0, in_ready}, 32'h1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule